// File: doc/BRIEF.md
# Serial Flash Command Register Front-End

This block is the register face of a serial NOR flash command controller. A host on a simple single-cycle read/write port loads an opcode, a flash address, a word-wide data buffer and a command configuration word. When the configuration word is written with its start bit set, the block latches every command field, raises a one-cycle launch request toward the serial sequencer, and shows the start bit as a busy flag until the sequencer reports that the command finished. Software either polls that bit or waits for the interrupt.

Completion, page-program failure and protected-address violation arrive from the sequencer as single-cycle pulses. Each one sets its own sticky raw status bit. A mask register gates the raw bits into a masked status view and an interrupt line, and a write-one-to-clear register removes raw bits. The data buffer is shared: the host fills or drains it through the register port, and the sequencer reads and writes words through a dedicated index port. A strap input picks 3-byte or 4-byte addressing and reads back through a read-only global configuration register. A read-only version register tells software which buffer depth (16 or 64 words) was built.

Top module: `fcmd_regfront`

## Requirements
- R1: After reset, launch and irq are 0, and the configuration, raw status, mask, opcode and address registers and every buffer word read 0.
- R2: A configuration write (word index 8) with bit 0 set while idle, and with an I/O mode other than 4, drives launch high for exactly the one cycle after the write. The command outputs then carry the written fields: bits 2:1 chip select, bit 3 address enable, bits 6:4 dummy bytes, bit 7 data enable, bit 8 read direction, bits 9 and up byte count minus one, bits 19:17 I/O mode. The configuration register reads back with bit 0 equal to 1.
- R3: Bit 0 of the configuration register reads 1 until the cycle after a seq_done pulse and reads 0 from then on. The pulse also sets raw status bit 0.
- R4: A configuration write while bit 0 reads 1 is ignored: there is no launch and the fields stay unchanged.
- R5: A configuration write with bit 0 set and I/O mode code 4 (reserved) is dropped: there is no launch, bit 0 stays 0 and the earlier fields stay unchanged.
- R6: A configuration write with bit 0 clear latches the fields without launching and leaves bit 0 at 0.
- R7: Raw status (word index 2) bit 0 is set by seq_done, bit 2 by seq_err_pp and bit 5 by seq_err_prot. Each bit stays set until it is cleared, and the other bits of the 9-bit field read 0.
- R8: Writing ones to the clear register (word index 5) clears the matching raw bits. A bit that is set and cleared in the same cycle stays set. The clear register reads 0.
- R9: Masked status (word index 3) equals raw AND mask (mask at word index 4, 9 bits), and irq is the OR of the masked status bits.
- R10: Global configuration (word index 0) bit 2 and cmd_addr4 follow addr4_strap. The version register (word index 1) reads 0x300 for 16 buffer words and 0x360 for 64.
- R11: Buffer word i sits at word index 64+i. Host writes are visible on seq_buf_rdata at index i, and sequencer writes are visible to host reads. Byte 0 of a transfer is bits 7:0 of word 0. When both sides write the same word in the same cycle, the sequencer's value is kept.
- R12: Opcode (word index 9, 8 bits) and address (word index 10, 32 bits) read back as written and drive cmd_opcode and cmd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata after the edge |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| addr4_strap | input | 1 | 1 selects 4-byte addressing |
| launch | output | 1 | One-cycle command launch request |
| cmd_opcode | output | 8 | Latched opcode |
| cmd_addr | output | 32 | Latched flash address |
| cmd_cs | output | 2 | Chip-select index |
| cmd_addr_en | output | 1 | Address phase present |
| cmd_dummy | output | 3 | Dummy byte count |
| cmd_data_en | output | 1 | Data phase present |
| cmd_dir_rd | output | 1 | 1 reads from flash |
| cmd_len_m1 | output | LEN_W | Data byte count minus one |
| cmd_io_mode | output | 3 | I/O mode code |
| cmd_addr4 | output | 1 | 4-byte addressing in use |
| seq_done | input | 1 | Sequencer command-finished pulse |
| seq_err_pp | input | 1 | Page-program error pulse |
| seq_err_prot | input | 1 | Protected-address error pulse |
| seq_buf_we | input | 1 | Sequencer buffer write |
| seq_buf_idx | input | IDX_W | Sequencer buffer word index |
| seq_buf_wdata | input | 32 | Sequencer buffer write data |
| seq_buf_rdata | output | 32 | Buffer word at seq_buf_idx |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The bench goes after the start bit's life cycle. It writes the configuration word again while a command is in flight, and a design that accepted that write would relaunch or corrupt the fields the sequencer is using. It starts a command with the reserved I/O mode, which a careless decoder would launch. It sets and clears raw bit 0 in the same cycle, where a design that gives the clear priority would lose a completion. It writes the same buffer word from both sides in one cycle, and a design with the priority reversed would keep the host's stale data instead of the flash data.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

   // Interrupt cause field
   localparam int IRQ_W       = 9;
   localparam int IRQ_DONE    = 0;
   localparam int IRQ_PPERR   = 2;
   localparam int IRQ_PROT    = 5;
   localparam logic [IRQ_W-1:0] IRQ_IMPL = 9'b0_0010_0101;

   // Register word indices
   localparam int R_GCFG   = 0;
   localparam int R_VER    = 1;
   localparam int R_RAW    = 2;
   localparam int R_MSKST  = 3;
   localparam int R_MASK   = 4;
   localparam int R_CLR    = 5;
   localparam int R_CFG    = 8;
   localparam int R_OPC    = 9;
   localparam int R_ADR    = 10;

   // Global configuration bit for address width
   localparam int GC_ADDR4 = 2;

   // Reserved I/O mode code
   localparam logic [2:0] IOM_RSVD = 3'd4;

   // Configuration word bits 19:1, packed in bit order
   typedef struct packed {
      logic [2:0] iom;     // 19:17
      logic [7:0] len;     // 16:9
      logic       dir;     // 8
      logic       den;     // 7
      logic [2:0] dummy;   // 6:4
      logic       aen;     // 3
      logic [1:0] cs;      // 2:1
   } cmd_cfg_t;

endpackage

// File: rtl/fcmd_cmd_regs.sv
module fcmd_cmd_regs
   import fcmd_pkg::*;
#(
   parameter int LEN_W = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic        opc_we,
   input  logic        adr_we,
   input  logic [31:0] wdata,
   input  logic        seq_done,
   output logic        busy,
   output logic        launch,
   output cmd_cfg_t    fields,
   output logic [7:0]  opcode,
   output logic [31:0] addr,
   output logic [31:0] cfg_rd
);

   localparam logic [7:0] LEN_MASK = 8'((1 << LEN_W) - 1);

   cmd_cfg_t   new_cfg;
   logic       start_req;
   logic       drop;
   logic       accept;
   logic       unused_hi;

   always_comb begin
      new_cfg     = cmd_cfg_t'(wdata[19:1]);
      new_cfg.len = new_cfg.len & LEN_MASK;
   end

   assign start_req = wdata[0];
   assign drop      = start_req && (new_cfg.iom == IOM_RSVD);
   assign accept    = cfg_we && !busy && !drop;
   assign unused_hi = ^wdata[31:20];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         launch <= 1'b0;
         fields <= '0;
      end else begin
         launch <= 1'b0;
         if (seq_done) begin
            busy <= 1'b0;
         end
         if (accept) begin
            fields <= new_cfg;
            busy   <= start_req;
            launch <= start_req;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode <= '0;
         addr   <= '0;
      end else begin
         if (opc_we) opcode <= wdata[7:0];
         if (adr_we) addr   <= wdata;
      end
   end

   assign cfg_rd = {12'd0, fields, busy};

endmodule

// File: rtl/fcmd_irq_bank.sv
module fcmd_irq_bank #(
   parameter int             W    = 9,
   parameter logic [W-1:0]   IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr_we,
   input  logic [W-1:0] clr_bits,
   input  logic         mask_we,
   input  logic [W-1:0] mask_bits,
   output logic [W-1:0] raw,
   output logic [W-1:0] mask,
   output logic [W-1:0] masked,
   output logic         irq
);

   logic unused_set;
   assign unused_set = ^(set_vec & ~IMPL);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flop
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= (r & ~(clr_we & clr_bits[i])) | set_vec[i];
         end
         assign raw[i] = r;
      end else begin : g_tie
         assign raw[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_bits;
   end

   assign masked = raw & mask;
   assign irq    = |masked;

endmodule

// File: rtl/fcmd_databuf.sv
module fcmd_databuf #(
   parameter int WORDS = 16,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             h_we,
   input  logic [IDX_W-1:0] h_idx,
   input  logic [31:0]      h_wdata,
   output logic [31:0]      h_rdata,
   input  logic             s_we,
   input  logic [IDX_W-1:0] s_idx,
   input  logic [31:0]      s_wdata,
   output logic [31:0]      s_rdata
);

   logic [31:0] mem [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[i] <= '0;
         end else if (s_we && (s_idx == IDX_W'(i))) begin
            mem[i] <= s_wdata;
         end else if (h_we && (h_idx == IDX_W'(i))) begin
            mem[i] <= h_wdata;
         end
      end
   end

   assign h_rdata = mem[h_idx];
   assign s_rdata = mem[s_idx];

endmodule

// File: rtl/fcmd_regfront.sv
module fcmd_regfront
   import fcmd_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          BUF_WORDS = 16,
   parameter int          BUF_BASE  = 64,
   parameter logic [31:0] VER_SMALL = 32'h0000_0300,
   parameter logic [31:0] VER_LARGE = 32'h0000_0360,
   localparam int         IDX_W     = $clog2(BUF_WORDS),
   localparam int         LEN_W     = $clog2(BUF_WORDS * 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              addr4_strap,
   output logic              launch,
   output logic [7:0]        cmd_opcode,
   output logic [31:0]       cmd_addr,
   output logic [1:0]        cmd_cs,
   output logic              cmd_addr_en,
   output logic [2:0]        cmd_dummy,
   output logic              cmd_data_en,
   output logic              cmd_dir_rd,
   output logic [LEN_W-1:0]  cmd_len_m1,
   output logic [2:0]        cmd_io_mode,
   output logic              cmd_addr4,
   input  logic              seq_done,
   input  logic              seq_err_pp,
   input  logic              seq_err_prot,
   input  logic              seq_buf_we,
   input  logic [IDX_W-1:0]  seq_buf_idx,
   input  logic [31:0]       seq_buf_wdata,
   output logic [31:0]       seq_buf_rdata,
   output logic              irq
);

   localparam logic [31:0] VERSION  = (BUF_WORDS == 64) ? VER_LARGE : VER_SMALL;
   localparam int          BUF_PAGE = BUF_BASE / BUF_WORDS;

   // Elaboration-time parameter checks
   if (BUF_WORDS != 16 && BUF_WORDS != 64) begin : g_bad_depth
      $error("fcmd_regfront: BUF_WORDS must be 16 or 64");
   end
   if ((BUF_BASE % BUF_WORDS) != 0 || BUF_BASE <= R_ADR) begin : g_bad_base
      $error("fcmd_regfront: BUF_BASE must be aligned and above the command registers");
   end
   if (BUF_BASE + BUF_WORDS > (1 << ADDR_W)) begin : g_bad_span
      $error("fcmd_regfront: buffer window exceeds the address space");
   end

   // Address decode
   logic in_buf;
   logic cfg_we, opc_we, adr_we, mask_we, clr_we, buf_we;

   assign in_buf  = (reg_addr[ADDR_W-1:IDX_W] == (ADDR_W-IDX_W)'(BUF_PAGE));
   assign cfg_we  = reg_wr && (reg_addr == ADDR_W'(R_CFG));
   assign opc_we  = reg_wr && (reg_addr == ADDR_W'(R_OPC));
   assign adr_we  = reg_wr && (reg_addr == ADDR_W'(R_ADR));
   assign mask_we = reg_wr && (reg_addr == ADDR_W'(R_MASK));
   assign clr_we  = reg_wr && (reg_addr == ADDR_W'(R_CLR));
   assign buf_we  = reg_wr && in_buf;

   // Command registers
   logic        busy_q;
   cmd_cfg_t    cfg_q;
   logic [31:0] cfg_rd;

   fcmd_cmd_regs #(.LEN_W(LEN_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .opc_we   (opc_we),
      .adr_we   (adr_we),
      .wdata    (reg_wdata),
      .seq_done (seq_done),
      .busy     (busy_q),
      .launch   (launch),
      .fields   (cfg_q),
      .opcode   (cmd_opcode),
      .addr     (cmd_addr),
      .cfg_rd   (cfg_rd)
   );

   assign cmd_cs      = cfg_q.cs;
   assign cmd_addr_en = cfg_q.aen;
   assign cmd_dummy   = cfg_q.dummy;
   assign cmd_data_en = cfg_q.den;
   assign cmd_dir_rd  = cfg_q.dir;
   assign cmd_len_m1  = cfg_q.len[LEN_W-1:0];
   assign cmd_io_mode = cfg_q.iom;
   assign cmd_addr4   = addr4_strap;

   // Interrupt bank
   logic [IRQ_W-1:0] irq_set;
   logic [IRQ_W-1:0] irq_raw;
   logic [IRQ_W-1:0] irq_mask;
   logic [IRQ_W-1:0] irq_masked;

   always_comb begin
      irq_set            = '0;
      irq_set[IRQ_DONE]  = seq_done;
      irq_set[IRQ_PPERR] = seq_err_pp;
      irq_set[IRQ_PROT]  = seq_err_prot;
   end

   fcmd_irq_bank #(.W(IRQ_W), .IMPL(IRQ_IMPL)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (irq_set),
      .clr_we    (clr_we),
      .clr_bits  (reg_wdata[IRQ_W-1:0]),
      .mask_we   (mask_we),
      .mask_bits (reg_wdata[IRQ_W-1:0]),
      .raw       (irq_raw),
      .mask      (irq_mask),
      .masked    (irq_masked),
      .irq       (irq)
   );

   // Data buffer
   logic [31:0] buf_rdata;

   fcmd_databuf #(.WORDS(BUF_WORDS)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .h_we    (buf_we),
      .h_idx   (reg_addr[IDX_W-1:0]),
      .h_wdata (reg_wdata),
      .h_rdata (buf_rdata),
      .s_we    (seq_buf_we),
      .s_idx   (seq_buf_idx),
      .s_wdata (seq_buf_wdata),
      .s_rdata (seq_buf_rdata)
   );

   // Registered read mux
   logic [31:0] rd_mux;
   logic        unused_len;

   assign unused_len = ^cfg_q.len;

   always_comb begin
      rd_mux = '0;
      if (in_buf) begin
         rd_mux = buf_rdata;
      end else begin
         case (reg_addr)
            ADDR_W'(R_GCFG):  rd_mux[GC_ADDR4] = addr4_strap;
            ADDR_W'(R_VER):   rd_mux = VERSION;
            ADDR_W'(R_RAW):   rd_mux[IRQ_W-1:0] = irq_raw;
            ADDR_W'(R_MSKST): rd_mux[IRQ_W-1:0] = irq_masked;
            ADDR_W'(R_MASK):  rd_mux[IRQ_W-1:0] = irq_mask;
            ADDR_W'(R_CFG):   rd_mux = cfg_rd;
            ADDR_W'(R_OPC):   rd_mux[7:0] = cmd_opcode;
            ADDR_W'(R_ADR):   rd_mux = cmd_addr;
            default:          rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

endmodule

// File: rtl/fcmd_regfront_chk.sv
module fcmd_regfront_chk
   import fcmd_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              seq_done,
   input logic              launch,
   input logic              busy,
   input logic [IRQ_W-1:0]  raw,
   input logic [IRQ_W-1:0]  mask,
   input logic              irq
);

   logic cfg_wr, clr_wr;
   assign cfg_wr = reg_wr && (reg_addr == ADDR_W'(R_CFG));
   assign clr_wr = reg_wr && (reg_addr == ADDR_W'(R_CLR));

   assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch);

   assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> busy);

   assert_done_idles_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && seq_done) |=> !busy);

   assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && busy) |=> !launch);

   assert_reserved_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && reg_wdata[0] && (reg_wdata[19:17] == IOM_RSVD)) |=> !launch);

   assert_raw_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[IRQ_DONE] && !(clr_wr && reg_wdata[IRQ_DONE])) |=> raw[IRQ_DONE]);

   assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> raw[IRQ_DONE]);

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);

endmodule

bind fcmd_regfront fcmd_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .seq_done  (seq_done),
   .launch    (launch),
   .busy      (busy_q),
   .raw       (irq_raw),
   .mask      (irq_mask),
   .irq       (irq)
);

// File: tb/tb_fcmd_regfront.sv
`timescale 1ns/1ps
module tb_fcmd_regfront;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        addr4_strap = 1'b0;
   logic        launch;
   logic [7:0]  cmd_opcode;
   logic [31:0] cmd_addr;
   logic [1:0]  cmd_cs;
   logic        cmd_addr_en, cmd_data_en, cmd_dir_rd, cmd_addr4;
   logic [2:0]  cmd_dummy, cmd_io_mode;
   logic [5:0]  cmd_len_m1;
   logic        seq_done = 1'b0, seq_err_pp = 1'b0, seq_err_prot = 1'b0;
   logic        seq_buf_we = 1'b0;
   logic [3:0]  seq_buf_idx = '0;
   logic [31:0] seq_buf_wdata = '0, seq_buf_rdata;
   logic        irq;

   always #2 clk = ~clk;   // 250 MHz

   fcmd_regfront dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .addr4_strap(addr4_strap), .launch(launch), .cmd_opcode(cmd_opcode),
      .cmd_addr(cmd_addr), .cmd_cs(cmd_cs), .cmd_addr_en(cmd_addr_en),
      .cmd_dummy(cmd_dummy), .cmd_data_en(cmd_data_en), .cmd_dir_rd(cmd_dir_rd),
      .cmd_len_m1(cmd_len_m1), .cmd_io_mode(cmd_io_mode), .cmd_addr4(cmd_addr4),
      .seq_done(seq_done), .seq_err_pp(seq_err_pp), .seq_err_prot(seq_err_prot),
      .seq_buf_we(seq_buf_we), .seq_buf_idx(seq_buf_idx),
      .seq_buf_wdata(seq_buf_wdata), .seq_buf_rdata(seq_buf_rdata), .irq(irq)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_pend = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: compares registered read data
   always @(posedge clk) rd_pend <= reg_rd;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: read with no expected item, actual=0x%0h expected=none", reg_rdata);
         end else begin
            chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); seq_done = 1'b1;
      @(negedge clk); seq_done = 1'b0;
   endtask

   localparam logic [7:0] A_GCFG = 0, A_VER = 1, A_RAW = 2, A_MST = 3, A_MASK = 4,
                          A_CLR = 5, A_CFG = 8, A_OPC = 9, A_ADR = 10, A_BUF = 64;
   // cs=2, aen, dummy=3, den, dir read, len-1=15, mode 6
   localparam logic [31:0] CFG_A = 32'h000C_1FBC;

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 launch", {31'd0, launch}, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      rd(A_CFG, 0, "R1 cfg");
      rd(A_RAW, 0, "R1 raw");
      rd(A_MASK, 0, "R1 mask");
      rd(A_OPC, 0, "R1 opcode");
      rd(A_BUF + 5, 0, "R1 buffer");

      // R10 strap and version
      addr4_strap = 1'b1;
      rd(A_GCFG, 32'h4, "R10 gcfg 4-byte");
      chk("R10 cmd_addr4", {31'd0, cmd_addr4}, 1);
      rd(A_VER, 32'h300, "R10 version");

      // R12 opcode and address
      wr(A_OPC, 32'h0000_00EB);
      wr(A_ADR, 32'h0012_3456);
      rd(A_OPC, 32'hEB, "R12 opcode rb");
      rd(A_ADR, 32'h0012_3456, "R12 addr rb");
      chk("R12 cmd_opcode", {24'd0, cmd_opcode}, 32'hEB);
      chk("R12 cmd_addr", cmd_addr, 32'h0012_3456);

      // R6 latch without start
      wr(A_CFG, CFG_A);
      chk("R6 no launch", {31'd0, launch}, 0);
      rd(A_CFG, CFG_A, "R6 cfg rb");
      chk("R6 cs", {30'd0, cmd_cs}, 2);
      chk("R6 dummy", {29'd0, cmd_dummy}, 3);
      chk("R6 len", {26'd0, cmd_len_m1}, 15);
      chk("R6 flags", {28'd0, cmd_addr_en, cmd_data_en, cmd_dir_rd, 1'b0}, 32'hE);
      chk("R6 mode", {29'd0, cmd_io_mode}, 6);

      // R2 start
      wr(A_CFG, CFG_A | 32'h1);
      chk("R2 launch high", {31'd0, launch}, 1);
      @(negedge clk);
      chk("R2 launch one cycle", {31'd0, launch}, 0);
      rd(A_CFG, CFG_A | 32'h1, "R2 start reads 1");

      // R4 write while busy
      wr(A_CFG, 32'h0000_0001);
      chk("R4 no relaunch", {31'd0, launch}, 0);
      chk("R4 mode kept", {29'd0, cmd_io_mode}, 6);
      rd(A_CFG, CFG_A | 32'h1, "R4 cfg unchanged");

      // R3 completion
      pulse_done();
      rd(A_CFG, CFG_A, "R3 start cleared");
      rd(A_RAW, 32'h1, "R3 raw done");

      // R9 mask
      chk("R9 irq masked off", {31'd0, irq}, 0);
      wr(A_MASK, 32'h1FF);
      chk("R9 irq on", {31'd0, irq}, 1);
      rd(A_MST, 32'h1, "R9 masked all");
      wr(A_MASK, 32'h004);
      chk("R9 irq off other mask", {31'd0, irq}, 0);
      rd(A_MST, 32'h0, "R9 masked none");

      // R7 error causes
      @(negedge clk); seq_err_pp = 1'b1;
      @(negedge clk); seq_err_pp = 1'b0;
      rd(A_RAW, 32'h5, "R7 pp error");
      chk("R7 irq pp", {31'd0, irq}, 1);
      @(negedge clk); seq_err_prot = 1'b1;
      @(negedge clk); seq_err_prot = 1'b0;
      rd(A_RAW, 32'h25, "R7 prot error");
      repeat (3) @(negedge clk);
      rd(A_RAW, 32'h25, "R7 sticky");

      // R8 clear
      wr(A_CLR, 32'h1);
      rd(A_RAW, 32'h24, "R8 clear bit0");
      rd(A_CLR, 32'h0, "R8 clear reads 0");
      @(negedge clk);
      seq_done = 1'b1; reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h1;
      @(negedge clk);
      seq_done = 1'b0; reg_wr = 1'b0;
      rd(A_RAW, 32'h25, "R8 set wins over clear");
      wr(A_CLR, 32'h1FF);
      rd(A_RAW, 32'h0, "R8 clear all");
      chk("R8 irq after clear", {31'd0, irq}, 0);

      // R5 reserved mode
      wr(A_CFG, 32'h0008_0001);
      chk("R5 no launch", {31'd0, launch}, 0);
      rd(A_CFG, CFG_A, "R5 dropped");

      // R2 second pattern: standard mode, 1 byte, no phases
      wr(A_CFG, 32'h0000_0001);
      chk("R2 launch std", {31'd0, launch}, 1);
      chk("R2 mode std", {29'd0, cmd_io_mode}, 0);
      chk("R2 len zero", {26'd0, cmd_len_m1}, 0);
      pulse_done();
      rd(A_CFG, 32'h0, "R3 idle again");

      // R11 buffer
      wr(A_BUF + 0, 32'hDDCC_BBAA);
      wr(A_BUF + 15, 32'h1234_5678);
      @(negedge clk); seq_buf_idx = 4'd0; #1;
      chk("R11 seq sees word0", seq_buf_rdata, 32'hDDCC_BBAA);
      chk("R11 byte0 in bits 7:0", {24'd0, seq_buf_rdata[7:0]}, 32'hAA);
      seq_buf_idx = 4'd15; #1;
      chk("R11 seq sees word15", seq_buf_rdata, 32'h1234_5678);
      @(negedge clk);
      seq_buf_we = 1'b1; seq_buf_idx = 4'd3; seq_buf_wdata = 32'hCAFE_F00D;
      @(negedge clk);
      seq_buf_we = 1'b0;
      rd(A_BUF + 3, 32'hCAFE_F00D, "R11 host sees seq write");
      @(negedge clk);
      seq_buf_we = 1'b1; seq_buf_idx = 4'd1; seq_buf_wdata = 32'h2222_2222;
      reg_wr = 1'b1; reg_addr = A_BUF + 1; reg_wdata = 32'h1111_1111;
      @(negedge clk);
      seq_buf_we = 1'b0; reg_wr = 1'b0;
      rd(A_BUF + 1, 32'h2222_2222, "R11 sequencer wins");

      addr4_strap = 1'b0;
      rd(A_GCFG, 32'h0, "R10 gcfg 3-byte");

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule